// File: doc/BRIEF.md
# Parallel BCD Integer Multiplier

This block multiplies two unsigned N-digit BCD integers and delivers the exact 2N-digit BCD product. Every multiplier digit is split into a few easy multiples of the multiplicand: the multiplicand itself, its double and its quintuple. All of these selections are made in the same cycle. The selected rows are shifted by their decimal position and converted to a 4-2-2-1 weighted digit code. A tree of decimal carry-save adders then reduces them to one sum/carry pair. A carry-propagate adder resolves that pair. It forms per-digit generate and propagate signals and solves the digit carries with a Kogge-Stone prefix network. The result digits come out in plain 8-4-2-1 BCD.

Operands arrive with a valid flag. Up to three optional register stages can be enabled by parameter: after row selection, after the reduction tree, and after the final adder. The valid flag moves through the same stages as the data. The latency is therefore fixed, and a new operand pair can be accepted on every cycle. Digit i of every bus occupies bits 4i+3 down to 4i, with the least significant digit at bit 0. N must be at least 2.

Top module: `dmul_core`

## Requirements
- R1: For BCD operands A and B, `out_prod` equals A×B as a 2N-digit BCD number, with digit i at bits 4i+3..4i and the least significant digit at bit 0.
- R2: Whenever `out_valid` is high, every 4-bit nibble of `out_prod` lies in 0..9.
- R3: The final adder never produces a carry beyond the most significant product digit. This includes the largest case, all-nines times all-nines, whose product is 9…98 0…01.
- R4: Each multiplier digit d in 0..9 is decomposed as 5·h + m1 + m2, with h in {0,1} and m1, m2 in {0,1,2}. Every one of the ten digit values yields a correct product.
- R5: `out_valid` rises exactly LAT = REG_PP + REG_CS + REG_OUT clock cycles after the cycle in which `in_valid` was sampled high (LAT is 3 by default). A cycle with `in_valid` low yields no `out_valid` pulse LAT cycles later.
- R6: A new operand pair may be presented on every cycle. Back-to-back results emerge on consecutive cycles, in issue order.
- R7: Reset is synchronous and active low. `out_valid` is low while `rst_n` is low, and it stays low after reset until a valid operand pair has reached the output.
- R8: If either operand is zero, the product is all-zero digits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand pair on `in_a`/`in_b` is valid this cycle |
| in_a | input | 4*N | Multiplicand, N BCD digits |
| in_b | input | 4*N | Multiplier, N BCD digits |
| out_valid | output | 1 | `out_prod` holds a finished product |
| out_prod | output | 8*N | Product, 2N BCD digits |

## Verification
Four properties are checked on every cycle:
- each multiplier digit's selected multiples sum back to that digit;
- each enabled register stage delays the valid flag by exactly one cycle;
- the prefix adder's carry out of the top digit stays clear whenever its inputs are valid;
- every output nibble is a legal BCD digit while `out_valid` is high.

Only the bench's scenarios can show that the product value is arithmetically right. It compares results against an integer reference for zero operands, all-nines operands, the full single-digit table, repeated-digit patterns and pseudo-random operands. The same scenarios, run with back-to-back and gapped issue, show the in-order throughput and the bubble behaviour.

// File: rtl/dmul_pkg.sv
`timescale 1ns/1ps
package dmul_pkg;

  typedef logic [3:0] nib_t;

  // Decomposition of one multiplier digit into easy multiples of A.
  typedef struct packed {
    logic       five;  // add 5A
    logic [1:0] m1;    // add 0, A or 2A
    logic [1:0] m2;    // add 0, A or 2A
  } dsel_t;

  // Value of a 4-2-2-1 weighted digit (bit3=4, bit2=2, bit1=2, bit0=1).
  function automatic nib_t val4221(input nib_t c);
    return {1'b0, c[3], 2'b00} + {2'b00, c[2], 1'b0} +
           {2'b00, c[1], 1'b0} + {3'b000, c[0]};
  endfunction

  // Encode a digit value 0..9 into the 4-2-2-1 code.
  function automatic nib_t enc4221(input nib_t d);
    nib_t r;
    case (d)
      4'd0: r = 4'b0000;
      4'd1: r = 4'b0001;
      4'd2: r = 4'b0010;
      4'd3: r = 4'b0011;
      4'd4: r = 4'b1000;
      4'd5: r = 4'b1001;
      4'd6: r = 4'b1010;
      4'd7: r = 4'b1011;
      4'd8: r = 4'b1110;
      4'd9: r = 4'b1111;
      default: r = 4'b0000;
    endcase
    return r;
  endfunction

  // Encode a digit value 0..9 into the 5-2-1-1 code (bit3=5, bit2=2, bit1=1, bit0=1).
  function automatic nib_t enc5211(input nib_t d);
    nib_t r;
    case (d)
      4'd0: r = 4'b0000;
      4'd1: r = 4'b0001;
      4'd2: r = 4'b0100;
      4'd3: r = 4'b0101;
      4'd4: r = 4'b0111;
      4'd5: r = 4'b1000;
      4'd6: r = 4'b1001;
      4'd7: r = 4'b1100;
      4'd8: r = 4'b1101;
      4'd9: r = 4'b1111;
      default: r = 4'b0000;
    endcase
    return r;
  endfunction

  // One digit of 2*X in 4-2-2-1: the 5-2-1-1 form shifted left by one bit,
  // the weight-5 bit of the lower digit entering as weight 1.
  function automatic nib_t dbl_digit(input nib_t cur, input nib_t low);
    nib_t sc;
    nib_t sl;
    sc = enc5211(val4221(cur));
    sl = enc5211(val4221(low));
    return {sc[2:0], sl[3]};
  endfunction

  // Digit of 5*A from plain BCD digits: 5*(a_i odd) + floor(a_{i-1}/2), never above 9.
  function automatic nib_t five_digit(input nib_t cur, input nib_t low);
    return (cur[0] ? 4'd5 : 4'd0) + {1'b0, low[3:1]};
  endfunction

  function automatic dsel_t recode_digit(input nib_t d);
    dsel_t s;
    nib_t  lo;
    s.five = (d >= 4'd5);
    lo     = s.five ? (d - 4'd5) : d;
    case (lo)
      4'd1:    begin s.m1 = 2'd1; s.m2 = 2'd0; end
      4'd2:    begin s.m1 = 2'd2; s.m2 = 2'd0; end
      4'd3:    begin s.m1 = 2'd2; s.m2 = 2'd1; end
      4'd4:    begin s.m1 = 2'd2; s.m2 = 2'd2; end
      default: begin s.m1 = 2'd0; s.m2 = 2'd0; end
    endcase
    return s;
  endfunction

  function automatic nib_t sel_weight(input dsel_t s);
    return (s.five ? 4'd5 : 4'd0) + {2'b00, s.m1} + {2'b00, s.m2};
  endfunction

  // Rows left after l levels of 3:2 reduction.
  function automatic int tree_rows(input int rows0, input int l);
    int c;
    c = rows0;
    for (int k = 0; k < l; k++) c = c - c / 3;
    return c;
  endfunction

  function automatic int tree_levels(input int rows0);
    int c;
    int n;
    c = rows0;
    n = 0;
    while (c > 2) begin
      c = c - c / 3;
      n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/dmul_pipe.sv
`timescale 1ns/1ps
module dmul_pipe #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld_i,
  input  logic [DW-1:0] dat_i,
  output logic          vld_o,
  output logic [DW-1:0] dat_o
);

  logic          vld_q;
  logic [DW-1:0] dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_i;
  end

  // Data is captured only with a valid operand; idle cycles leave it untouched.
  always_ff @(posedge clk) begin
    if (vld_i) dat_q <= dat_i;
  end

  assign vld_o = vld_q;
  assign dat_o = dat_q;

  // R5: each stage delays the valid flag by exactly one cycle
  p_valid_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o == $past(vld_i));

endmodule

// File: rtl/dmul_ppgen.sv
`timescale 1ns/1ps
module dmul_ppgen import dmul_pkg::*; #(
  parameter int N = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [4*N-1:0]   a_i,
  input  logic [4*N-1:0]   b_i,
  output logic [8*N-1:0]   rows_o [3*N]
);

  localparam int W  = 2 * N;
  localparam int AD = N + 1;          // digits of a multiple of A
  localparam int PAD = 4 * (W - AD);  // zero digits above a multiple

  logic [4*AD-1:0] a_ext;
  logic [4*AD-1:0] a_4221;
  logic [4*AD-1:0] two_4221;
  logic [4*AD-1:0] five_4221;
  logic [4*W-1:0]  a_w;
  logic [4*W-1:0]  two_w;
  logic [4*W-1:0]  five_w;

  assign a_ext = {4'h0, a_i};

  // Easy multiples of A, all in 4-2-2-1 code.
  always_comb begin
    nib_t prev_c;
    nib_t prev_b;
    prev_c = 4'h0;
    prev_b = 4'h0;
    for (int i = 0; i < AD; i++) begin
      a_4221[4*i +: 4]    = enc4221(a_ext[4*i +: 4]);
      five_4221[4*i +: 4] = enc4221(five_digit(a_ext[4*i +: 4], prev_b));
      two_4221[4*i +: 4]  = dbl_digit(a_4221[4*i +: 4], prev_c);
      prev_c = a_4221[4*i +: 4];
      prev_b = a_ext[4*i +: 4];
    end
  end

  assign a_w    = {{PAD{1'b0}}, a_4221};
  assign two_w  = {{PAD{1'b0}}, two_4221};
  assign five_w = {{PAD{1'b0}}, five_4221};

  function automatic logic [4*W-1:0] pick(input logic [1:0] m,
                                         input logic [4*W-1:0] one,
                                         input logic [4*W-1:0] two);
    case (m)
      2'd1:    return one;
      2'd2:    return two;
      default: return '0;
    endcase
  endfunction

  for (genvar j = 0; j < N; j++) begin : g_digit
    dsel_t sel;
    assign sel = recode_digit(b_i[4*j +: 4]);

    assign rows_o[3*j]     = sel.five ? (five_w << (4*j)) : '0;
    assign rows_o[3*j + 1] = pick(sel.m1, a_w, two_w) << (4*j);
    assign rows_o[3*j + 2] = pick(sel.m2, a_w, two_w) << (4*j);

    // R4: the chosen multiples add back up to the multiplier digit
    p_recode_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (sel_weight(sel) == b_i[4*j +: 4]));
  end

endmodule

// File: rtl/dmul_cs_tree.sv
`timescale 1ns/1ps
module dmul_cs_tree import dmul_pkg::*; #(
  parameter int W    = 16,
  parameter int ROWS = 24
) (
  input  logic [4*W-1:0] rows_i [ROWS],
  output logic [4*W-1:0] sum_o,
  output logic [4*W-1:0] car_o
);

  localparam int LEVELS = tree_levels(ROWS);

  function automatic logic [4*W-1:0] cs_sum(input logic [4*W-1:0] x,
                                           input logic [4*W-1:0] y,
                                           input logic [4*W-1:0] z);
    return x ^ y ^ z;
  endfunction

  // Majority carry, doubled in 4-2-2-1 and moved one decimal position up.
  function automatic logic [4*W-1:0] cs_carry2(input logic [4*W-1:0] x,
                                              input logic [4*W-1:0] y,
                                              input logic [4*W-1:0] z);
    logic [4*W-1:0] h;
    logic [4*W-1:0] r;
    nib_t prev;
    h = (x & y) | (x & z) | (y & z);
    prev = 4'h0;
    for (int i = 0; i < W; i++) begin
      r[4*i +: 4] = dbl_digit(h[4*i +: 4], prev);
      prev = h[4*i +: 4];
    end
    return r;
  endfunction

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int CI = tree_rows(ROWS, l);
    localparam int GI = CI / 3;
    localparam int CO = CI - GI;
    logic [4*W-1:0] cur [CI];
    logic [4*W-1:0] nxt [CO];

    if (l == 0) begin : g_src
      for (genvar k = 0; k < CI; k++) begin : g_k
        assign cur[k] = rows_i[k];
      end
    end else begin : g_chain
      for (genvar k = 0; k < CI; k++) begin : g_k
        assign cur[k] = g_lvl[l-1].nxt[k];
      end
    end

    for (genvar m = 0; m < CO; m++) begin : g_out
      if (m < 2 * GI) begin : g_csa
        if (m % 2 == 0) begin : g_s
          assign nxt[m] = cs_sum(cur[3*(m/2)], cur[3*(m/2)+1], cur[3*(m/2)+2]);
        end else begin : g_c
          assign nxt[m] = cs_carry2(cur[3*(m/2)], cur[3*(m/2)+1], cur[3*(m/2)+2]);
        end
      end else begin : g_pass
        assign nxt[m] = cur[m + GI];
      end
    end
  end

  assign sum_o = g_lvl[LEVELS-1].nxt[0];
  assign car_o = g_lvl[LEVELS-1].nxt[1];

endmodule

// File: rtl/dmul_ks_add.sv
`timescale 1ns/1ps
module dmul_ks_add import dmul_pkg::*; #(
  parameter int W = 16
) (
  input  logic [4*W-1:0] x_i,
  input  logic [4*W-1:0] y_i,
  output logic [4*W-1:0] sum_o,
  output logic           cout_o
);

  logic [4:0]   dsum [W];
  logic [W-1:0] dgen;
  logic [W-1:0] dprp;
  logic [W-1:0] gpre;
  logic [W-1:0] cin;

  // Kogge-Stone prefix: log2(W) levels of (G,P) combination.
  function automatic logic [W-1:0] ks_prefix(input logic [W-1:0] g,
                                            input logic [W-1:0] p);
    logic [W-1:0] gg;
    logic [W-1:0] pp;
    gg = g;
    pp = p;
    for (int d = 1; d < W; d = d * 2) begin
      gg = gg | (pp & (gg << d));
      pp = pp & (pp << d);
    end
    return gg;
  endfunction

  always_comb begin
    for (int i = 0; i < W; i++) begin
      dsum[i] = {1'b0, val4221(x_i[4*i +: 4])} + {1'b0, val4221(y_i[4*i +: 4])};
      dgen[i] = (dsum[i] >= 5'd10);
      dprp[i] = (dsum[i] == 5'd9);
    end
  end

  assign gpre   = ks_prefix(dgen, dprp);
  assign cin    = {gpre[W-2:0], 1'b0};
  assign cout_o = gpre[W-1];

  always_comb begin
    logic [4:0] t;
    for (int i = 0; i < W; i++) begin
      t = dsum[i] + {4'd0, cin[i]};
      sum_o[4*i +: 4] = (t >= 5'd10) ? 4'(t - 5'd10) : t[3:0];
    end
  end

endmodule

// File: rtl/dmul_core.sv
`timescale 1ns/1ps
module dmul_core import dmul_pkg::*; #(
  parameter int N       = 8,
  parameter int REG_PP  = 1,
  parameter int REG_CS  = 1,
  parameter int REG_OUT = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [4*N-1:0] in_a,
  input  logic [4*N-1:0] in_b,
  output logic           out_valid,
  output logic [8*N-1:0] out_prod
);

  localparam int W    = 2 * N;
  localparam int ROWS = 3 * N;
  localparam int RW   = ROWS * 4 * W;

  // ---------------- row selection ----------------
  logic [4*W-1:0] pp_rows [ROWS];
  logic [RW-1:0]  pp_flat;
  logic [RW-1:0]  pp_flat_q;
  logic           v1;

  dmul_ppgen #(.N(N)) u_ppgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .a_i      (in_a),
    .b_i      (in_b),
    .rows_o   (pp_rows)
  );

  for (genvar k = 0; k < ROWS; k++) begin : g_pack
    assign pp_flat[k*4*W +: 4*W] = pp_rows[k];
  end

  if (REG_PP != 0) begin : g_r1
    dmul_pipe #(.DW(RW)) u_r1 (
      .clk(clk), .rst_n(rst_n), .vld_i(in_valid), .dat_i(pp_flat),
      .vld_o(v1), .dat_o(pp_flat_q)
    );
  end else begin : g_w1
    assign v1        = in_valid;
    assign pp_flat_q = pp_flat;
  end

  // ---------------- carry-save reduction ----------------
  logic [4*W-1:0] tr_rows [ROWS];
  logic [4*W-1:0] cs_sum;
  logic [4*W-1:0] cs_car;
  logic [8*W-1:0] cs_pair;
  logic [8*W-1:0] cs_pair_q;
  logic           v2;

  for (genvar k = 0; k < ROWS; k++) begin : g_unpack
    assign tr_rows[k] = pp_flat_q[k*4*W +: 4*W];
  end

  dmul_cs_tree #(.W(W), .ROWS(ROWS)) u_tree (
    .rows_i (tr_rows),
    .sum_o  (cs_sum),
    .car_o  (cs_car)
  );

  assign cs_pair = {cs_sum, cs_car};

  if (REG_CS != 0) begin : g_r2
    dmul_pipe #(.DW(8*W)) u_r2 (
      .clk(clk), .rst_n(rst_n), .vld_i(v1), .dat_i(cs_pair),
      .vld_o(v2), .dat_o(cs_pair_q)
    );
  end else begin : g_w2
    assign v2        = v1;
    assign cs_pair_q = cs_pair;
  end

  // ---------------- carry-propagate adder ----------------
  logic [4*W-1:0] add_sum;
  logic           add_cout;

  dmul_ks_add #(.W(W)) u_add (
    .x_i    (cs_pair_q[8*W-1:4*W]),
    .y_i    (cs_pair_q[4*W-1:0]),
    .sum_o  (add_sum),
    .cout_o (add_cout)
  );

  // R3: the product always fits in 2N digits
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    v2 |-> !add_cout);

  if (REG_OUT != 0) begin : g_r3
    dmul_pipe #(.DW(4*W)) u_r3 (
      .clk(clk), .rst_n(rst_n), .vld_i(v2), .dat_i(add_sum),
      .vld_o(out_valid), .dat_o(out_prod)
    );
  end else begin : g_w3
    assign out_valid = v2;
    assign out_prod  = add_sum;
  end

  function automatic logic all_bcd(input logic [8*N-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < W; i++) if (v[4*i +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  // R2: only legal decimal digits leave the block
  p_bcd_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> all_bcd(out_prod));

endmodule

// File: tb/dmul_core_bench.sv
`timescale 1ns/1ps
module dmul_core_bench;

  localparam int N    = 8;
  localparam int RPP  = 1;
  localparam int RCS  = 1;
  localparam int ROUT = 1;
  localparam int LAT  = RPP + RCS + ROUT;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic [4*N-1:0] in_a = '0;
  logic [4*N-1:0] in_b = '0;
  logic           out_valid;
  logic [8*N-1:0] out_prod;

  dmul_core #(.N(N), .REG_PP(RPP), .REG_CS(RCS), .REG_OUT(ROUT)) u_dmul_core (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_prod(out_prod)
  );

  always #4 clk = ~clk;  // 125 MHz

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit mon_en = 1'b0;
  bit finished = 1'b0;
  int unsigned seed = 32'h1234_5678;

  logic [8*N-1:0] q_exp [$];
  int             q_due [$];
  string          q_tag [$];

  function automatic longint unsigned bcd_val(input logic [8*N-1:0] v);
    longint unsigned r;
    r = 0;
    for (int i = 2*N-1; i >= 0; i--) r = r * 10 + longint'(v[4*i +: 4]);
    return r;
  endfunction

  function automatic logic [8*N-1:0] to_bcd(input longint unsigned x);
    logic [8*N-1:0] r;
    longint unsigned t;
    t = x;
    for (int i = 0; i < 2*N; i++) begin
      r[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  function automatic bit digits_ok(input logic [8*N-1:0] v);
    for (int i = 0; i < 2*N; i++) if (v[4*i +: 4] > 4'd9) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [4*N-1:0] rand_bcd();
    logic [4*N-1:0] r;
    for (int i = 0; i < N; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      r[4*i +: 4] = 4'((seed >> 16) % 10);
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [8*N-1:0] act, input logic [8*N-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Output monitor, sampling 2 ns after each rising edge.
  always @(posedge clk) begin
    #2;
    cyc++;
    if (mon_en) begin
      if (out_valid) begin
        if (q_exp.size() == 0) begin
          check(1'b0, "R5 unexpected out_valid", out_prod, '0);
        end else begin
          logic [8*N-1:0] e;
          int d;
          string t;
          e = q_exp.pop_front();
          d = q_due.pop_front();
          t = q_tag.pop_front();
          check(d == cyc, {t, " R5 latency"}, 64'(cyc), 64'(d));
          check(out_prod == e, t, out_prod, e);
          check(digits_ok(out_prod), "R2 digit range", out_prod, e);
        end
      end else if (q_due.size() > 0 && q_due[0] <= cyc) begin
        check(1'b0, {q_tag[0], " R5 missing out_valid"}, '0, q_exp[0]);
        void'(q_exp.pop_front());
        void'(q_due.pop_front());
        void'(q_tag.pop_front());
      end
    end
  end

  task automatic put(input logic [4*N-1:0] a, input logic [4*N-1:0] b, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_a = a;
    in_b = b;
    q_exp.push_back(to_bcd(bcd_val({{(4*N){1'b0}}, a}) * bcd_val({{(4*N){1'b0}}, b})));
    q_due.push_back(cyc + LAT);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic drain();
    idle(LAT + 2);
    check(q_exp.size() == 0, "R5 results outstanding", 64'(q_exp.size()), '0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R7 out_valid in reset", 64'(out_valid), '0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    mon_en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R7 out_valid idle after reset", 64'(out_valid), '0);
    end
  endtask

  task automatic t_zero();
    put(32'h0000_0000, 32'h1234_5678, "R8 zero A");
    put(32'h8765_4321, 32'h0000_0000, "R8 zero B");
    put(32'h0000_0000, 32'h0000_0000, "R8 zero both");
    drain();
  endtask

  task automatic t_nines();
    put(32'h9999_9999, 32'h9999_9999, "R3 all nines");
    put(32'h9999_9999, 32'h0000_0001, "R1 nines times one");
    drain();
  endtask

  task automatic t_single_digit();
    for (int a = 0; a < 10; a++)
      for (int b = 0; b < 10; b++)
        put(32'(a), 32'(b), "R4 single digit table");
    drain();
  endtask

  task automatic t_repeat_digit();
    for (int d = 0; d < 10; d++) begin
      logic [4*N-1:0] rep;
      for (int i = 0; i < N; i++) rep[4*i +: 4] = 4'(d);
      put(32'h1234_5678, rep, "R4 repeated multiplier digit");
      put(rep, 32'h9087_6543, "R1 repeated multiplicand digit");
    end
    drain();
  endtask

  task automatic t_random_stream();
    for (int i = 0; i < 150; i++) put(rand_bcd(), rand_bcd(), "R6 back-to-back");
    drain();
  endtask

  task automatic t_bubbles();
    for (int i = 0; i < 12; i++) begin
      put(rand_bcd(), rand_bcd(), "R5 gapped issue");
      idle((i % 3) + 1);
    end
    drain();
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R5 watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_zero();
    t_nines();
    t_single_digit();
    t_repeat_digit();
    t_random_stream();
    t_bubbles();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule